// File: doc/BRIEF.md
# Triggered Triangle Wave Generator

This block adds a triangle ramp to a held base sample for one converter channel. Each accepted trigger moves an internal up/down counter by one count. The counter runs from zero up to a peak set by a 4-bit amplitude code, then back down to zero, and repeats. The value sent to the converter's output register is the base sample plus the counter, clipped at full scale.

The amplitude code is captured when the channel is enabled. After that it stays fixed until the channel is disabled, so software cannot change the ramp height while a waveform is playing. Disabling the channel returns the counter to zero and the direction to rising. Steps are taken only while the trigger gate is open.

Top module: `tri_wave_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `wave_out` equals `base_data`, because the counter is zero.
- R2: One rising edge of `trig_pulse` that is accepted moves the counter by exactly one count. With base 0xABE, three accepted triggers give 0xABF, 0xAC0 and 0xAC1 in turn.
- R3: The counter rises from 0 to the peak and then falls back to 0. At each end it turns on the next step, so no end value appears twice in a row (peak 3 gives 1,2,3,2,1,0,1).
- R4: Amplitude code n sets the peak to 2^(n+1)-1. Codes 11 to 15 all give a peak of 4095.
- R5: `amp_sel` is captured in the first clock cycle in which `chan_en` is seen high. Changes to it while `chan_en` stays high have no effect on the peak.
- R6: When `trig_en` is low, trigger pulses cause no step and `wave_out` holds its value.
- R7: When `chan_en` is low, the counter is forced to 0 and the direction to rising. A trigger in the same cycle in which `chan_en` is first seen high is not accepted.
- R8: `wave_out` is `base_data` plus the counter, saturated at 0xFFF rather than wrapped.
- R9: `wave_out` follows a change of `base_data` in the same cycle, with the counter unchanged.
- R10: Only the rising edge of `trig_pulse` counts. A pulse held high for several cycles causes a single step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable. Captures the amplitude when it goes high and clears the counter while low |
| trig_en | input | 1 | Trigger gate. Steps are taken only while it is high |
| trig_pulse | input | 1 | Trigger strobe. Its rising edge requests one step |
| amp_sel | input | 4 | Amplitude code |
| base_data | input | 12 | Held base sample |
| wave_out | output | 12 | Base sample plus triangle counter, saturated |

## Verification
An accepted trigger is registered on the clock edge at which it is sampled. Its new count therefore appears at `wave_out` just after that edge. A change of `base_data` reaches `wave_out` through logic only, with no register in the path. The amplitude capture and the enabled flag each take one edge, so a trigger can be accepted no earlier than the second edge after `chan_en` rises. The bench drives all inputs one time step after a rising edge and checks the output right after the edge at which the result is due. It never samples at an edge itself.

// File: rtl/triwave_pkg.sv
package triwave_pkg;
  localparam int DATA_W = 12;
  localparam int AMP_W  = 4;

  // Peak for an amplitude code: 2^(code+1)-1, clipped to full scale
  function automatic logic [DATA_W-1:0] peak_of(input logic [AMP_W-1:0] code);
    if (int'(code) >= DATA_W - 1) return '1;
    return DATA_W'((1 << (int'(code) + 1)) - 1);
  endfunction

  // Base plus ramp with clipping at full scale
  function automatic logic [DATA_W-1:0] sat_add(input logic [DATA_W-1:0] base,
                                                 input logic [DATA_W-1:0] ramp);
    logic [DATA_W:0] s;
    s = {1'b0, base} + {1'b0, ramp};
    return s[DATA_W] ? '1 : s[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/tri_amp_lock.sv
module tri_amp_lock
  import triwave_pkg::*;
#(
  parameter int AW = AMP_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic [AW-1:0] amp_sel,
  output logic [AW-1:0] amp_q,
  output logic          armed,
  output logic [DW-1:0] peak
);
  logic en_q;
  logic capture;

  assign capture = chan_en && !en_q;
  assign armed   = en_q;
  assign peak    = peak_of(amp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      amp_q <= '0;
    end else begin
      en_q <= chan_en;
      if (capture) amp_q <= amp_sel;
    end
  end
endmodule

// File: rtl/tri_step_counter.sv
module tri_step_counter #(
  parameter int DW = triwave_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          armed,
  input  logic          trig_en,
  input  logic          trig_pulse,
  input  logic [DW-1:0] peak,
  output logic [DW-1:0] cnt,
  output logic          dir_down,
  output logic          step
);
  logic trig_q;

  assign step = chan_en && armed && trig_en && trig_pulse && !trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_down <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      trig_q <= trig_pulse;
      if (!chan_en) begin
        cnt      <= '0;
        dir_down <= 1'b0;
      end else if (step) begin
        if (!dir_down) begin
          if (cnt >= peak) begin
            dir_down <= 1'b1;
            cnt      <= cnt - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          if (cnt == '0) begin
            dir_down <= 1'b0;
            cnt      <= DW'(1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tri_sat_sum.sv
module tri_sat_sum
  import triwave_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] ramp,
  output logic [DW-1:0] sum,
  output logic          clipped
);
  logic [DW:0] raw;
  assign raw     = {1'b0, base} + {1'b0, ramp};
  assign clipped = raw[DW];
  assign sum     = sat_add(base, ramp);
endmodule

// File: rtl/tri_wave_gen.sv
module tri_wave_gen
  import triwave_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = AMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          trig_en,
  input  logic          trig_pulse,
  input  logic [AW-1:0] amp_sel,
  input  logic [DW-1:0] base_data,
  output logic [DW-1:0] wave_out
);
  logic [AW-1:0] amp_q;
  logic          armed;
  logic [DW-1:0] peak;
  logic [DW-1:0] cnt;
  logic          dir_down;
  logic          step;
  logic          clipped;

  tri_amp_lock #(.AW(AW), .DW(DW)) u_lock (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .amp_sel(amp_sel),
    .amp_q(amp_q), .armed(armed), .peak(peak)
  );

  tri_step_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .armed(armed),
    .trig_en(trig_en), .trig_pulse(trig_pulse), .peak(peak),
    .cnt(cnt), .dir_down(dir_down), .step(step)
  );

  tri_sat_sum #(.DW(DW)) u_sum (
    .base(base_data), .ramp(cnt), .sum(wave_out), .clipped(clipped)
  );
endmodule

// File: rtl/tri_wave_chk.sv
module tri_wave_chk #(
  parameter int DW = 12,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          armed,
  input logic          step,
  input logic [AW-1:0] amp_q,
  input logic [DW-1:0] peak,
  input logic [DW-1:0] cnt,
  input logic          clipped,
  input logic [DW-1:0] base_data,
  input logic [DW-1:0] wave_out
);
  // R2
  one_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));

  // R6
  hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !step) |=> $stable(cnt));

  // R5
  amp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && armed) |=> $stable(amp_q));

  // R7
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (cnt == '0));

  // R3
  within_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= peak);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_out >= base_data) && (!clipped || wave_out == '1));
endmodule

bind tri_wave_gen tri_wave_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .armed(armed), .step(step),
  .amp_q(amp_q), .peak(peak), .cnt(cnt), .clipped(clipped),
  .base_data(base_data), .wave_out(wave_out)
);

// File: tb/tb_tri_wave_gen.sv
`timescale 1ns/1ps
module tb_tri_wave_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0;
  logic        trig_en = 1'b0;
  logic        trig_pulse = 1'b0;
  logic [3:0]  amp_sel = '0;
  logic [11:0] base_data = '0;
  logic [11:0] wave_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  tri_wave_gen dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig_en(trig_en),
    .trig_pulse(trig_pulse), .amp_sel(amp_sel), .base_data(base_data),
    .wave_out(wave_out)
  );

  // {amp code, base, trigger count, expected output}
  localparam logic [39:0] VEC [10] = '{
    {4'd0,  12'h100, 12'd3,  12'h101},
    {4'd2,  12'hABE, 12'd2,  12'hAC0},
    {4'd2,  12'h000, 12'd9,  12'h005},
    {4'd3,  12'h200, 12'd16, 12'h20E},
    {4'd1,  12'h010, 12'd6,  12'h010},
    {4'd1,  12'h010, 12'd7,  12'h011},
    {4'd11, 12'hFF0, 12'd20, 12'hFFF},
    {4'd15, 12'h000, 12'd40, 12'h028},
    {4'd4,  12'hFE0, 12'd31, 12'hFFF},
    {4'd4,  12'hFE0, 12'd32, 12'hFFE}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse();
    trig_pulse = 1'b1;
    tick();
    trig_pulse = 1'b0;
    tick();
  endtask

  task automatic check(input string req, input logic [11:0] exp);
    checks++;
    if (wave_out !== exp) begin
      fails++;
      $display("FAIL %s: wave_out actual=%h expected=%h", req, wave_out, exp);
    end
  endtask

  task automatic restart(input logic [3:0] a, input logic [11:0] b);
    chan_en = 1'b0;
    tick();
    amp_sel   = a;
    base_data = b;
    chan_en   = 1'b1;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R2: watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    base_data = 12'h123;
    #2;
    check("R1 in reset", 12'h123);
    tick();
    tick();
    rst_n = 1'b1;
    tick();
    check("R1 after reset", 12'h123);
    trig_en = 1'b1;

    // Vector table (R2 R3 R4 R8)
    for (int i = 0; i < 10; i++) begin
      restart(VEC[i][39:36], VEC[i][35:24]);
      for (int k = 0; k < int'(VEC[i][23:12]); k++) pulse();
      check("R3/R4/R8 vector", VEC[i][11:0]);
    end

    // R2: single steps from 0xABE
    restart(4'd5, 12'hABE);
    check("R2 start", 12'hABE);
    pulse(); check("R2 step1", 12'hABF);
    pulse(); check("R2 step2", 12'hAC0);
    pulse(); check("R2 step3", 12'hAC1);

    // R9: base change seen in the same cycle
    base_data = 12'h400;
    #1;
    check("R9 base follow", 12'h403);

    // R6: trigger gate closed
    trig_en = 1'b0;
    pulse(); pulse();
    check("R6 gated hold", 12'h403);
    trig_en = 1'b1;

    // R10: held pulse gives one step
    trig_pulse = 1'b1;
    repeat (5) tick();
    trig_pulse = 1'b0;
    tick();
    check("R10 held pulse", 12'h404);

    // R7: disable clears counter
    chan_en = 1'b0;
    tick();
    check("R7 cleared", 12'h400);
    // R7: trigger in the enable cycle not accepted
    chan_en = 1'b1;
    trig_pulse = 1'b1;
    tick();
    trig_pulse = 1'b0;
    tick();
    check("R7 enable-cycle trigger", 12'h400);
    pulse();
    check("R7 direction up", 12'h401);

    // R5: amplitude change while enabled ignored (peak 1)
    restart(4'd0, 12'h050);
    amp_sel = 4'd5;
    pulse(); pulse(); pulse();
    check("R5 amp locked", 12'h051);
    pulse();
    check("R5 amp locked fall", 12'h050);

    // R3: turn at peak 3 without repeating end values
    restart(4'd1, 12'h000);
    pulse(); pulse(); pulse();
    check("R3 at peak", 12'h003);
    pulse();
    check("R3 after peak", 12'h002);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule